// File: doc/BRIEF.md
# Masked Packed Float-to-Int64 Conversion Unit

This unit turns a vector of single-precision floating-point elements into 64-bit signed integers. Each lane has its own scalar converter. A length select picks how many lanes are live: 2, 4 or 8. A per-lane write mask with merge or zero behaviour decides what each lane writes. All destination bits above the chosen length are cleared.

When the operand comes from memory, the unit can replicate element 0 into every lane. When the operand is a register and the vector is full width, the caller can supply a rounding code that replaces the global rounding mode for this one operation. A 4-bit reserved operand field must read all ones; any other value raises a fault and suppresses the result.

The caller presents one operation with a single-cycle `in_valid` strobe. The result, the two sticky-style flags and the fault appear one clock later, together with a one-cycle `out_valid` pulse. The outputs then hold until the next strobe.

Top module: `pack_cvt_unit`

## Requirements
- R1: The destination, flags and fault for a strobed operation appear on the first rising edge after `in_valid`, with `out_valid` high for exactly that one cycle; the outputs keep their values while no strobe arrives. After reset, every output is 0.
- R2: `vlen` selects the number of live lanes: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes. Destination bits of every lane at or above that count read 0 whatever the mask and the old destination hold.
- R3: Lane j converts source bits [32j+31:32j] and writes destination bits [64j+63:64j].
- R4: The rounding code selects how inexact values round: 2'b00 to nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero.
- R5: `er_rc` is the rounding code only when all three hold: `vlen` is 2'b10 or 2'b11, `src_is_mem`=0 and `er_en`=1. In every other case `glb_rc` is used.
- R6: With `src_is_mem`=1 and `bcast`=1, every lane converts source bits [31:0]. With `src_is_mem`=0, `bcast` has no effect.
- R7: A live lane converts when `mask_en`=0 or its `wmask` bit is 1.
- R8: A live lane that does not convert keeps its `old_dst` lane when `zero_mode`=0, and writes 0 when `zero_mode`=1.
- R9: A NaN, an infinity, or a rounded value outside the signed 64-bit range writes 64'h8000_0000_0000_0000 and raises `flag_inv`. Exactly -2^63 converts to that same value with no flag.
- R10: `flag_inx` is raised when a converting lane discards nonzero fraction bits.
- R11: Each flag is the OR over live, converting lanes only. Masked-off lanes and lanes above the length never raise a flag.
- R12: If `rsvd` is not 4'b1111, `ud_fault` is 1, the destination equals `old_dst` unchanged, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 256 | Packed single-precision source elements |
| old_dst | input | 512 | Previous destination contents |
| wmask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | 1 applies the write mask |
| zero_mode | input | 1 | 1 zeroes masked lanes, 0 merges them |
| vlen | input | 2 | Vector length select |
| bcast | input | 1 | Replicate element 0 (memory source only) |
| src_is_mem | input | 1 | 1 when the operand comes from memory |
| er_en | input | 1 | Enable the per-operation rounding code |
| er_rc | input | 2 | Per-operation rounding code |
| glb_rc | input | 2 | Global rounding mode |
| rsvd | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result strobe, one cycle |
| dst | output | 512 | Converted destination |
| flag_inv | output | 1 | Invalid-conversion flag |
| flag_inx | output | 1 | Inexact flag |
| ud_fault | output | 1 | Reserved-field fault |

## Verification
The bench drives ties and negative halves through all four rounding codes. A converter that biases the wrong way on a tie, or truncates instead of flooring negatives, gives 3 in place of 2 or -1 in place of -2.

It applies the rounding override with a memory source and with a half-width vector; a unit that ignores either gating condition rounds 2.5 to 3 there. It sets the broadcast bit on a register source, where a leak would copy element 0 into all lanes.

Range checks cover exactly -2^63, which must stay flag-free, and +2^63, which must not. A NaN placed in a masked lane and another above the length must not reach the invalid flag. A faulting operation with NaN inputs must return the old destination with no flags; a unit that still wrote results would show converted lanes there.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_t;

  localparam int unsigned FW = 32;
  localparam int unsigned IW = 64;
  localparam logic [IW-1:0] INT_INDEF = {1'b1, {(IW-1){1'b0}}};
endpackage

// File: rtl/cvt_rc_sel.sv
module cvt_rc_sel
  import cvt_pkg::*;
(
  input  logic [1:0] vlen,
  input  logic       src_is_mem,
  input  logic       er_en,
  input  logic [1:0] er_rc,
  input  logic [1:0] glb_rc,
  output rmode_t     rm
);
  logic full_len;

  always_comb begin
    full_len = vlen[1];
    if (full_len && !src_is_mem && er_en) rm = rmode_t'(er_rc);
    else                                  rm = rmode_t'(glb_rc);
  end
endmodule

// File: rtl/cvt_f32_i64.sv
module cvt_f32_i64
  import cvt_pkg::*;
(
  input  logic [FW-1:0] f,
  input  rmode_t        rm,
  output logic [IW-1:0] q,
  output logic          inv,
  output logic          inx
);
  logic          s;
  logic [7:0]    e;
  logic [23:0]   sig;
  logic [5:0]    lsh;
  logic [7:0]    rsh;
  logic [49:0]   wide;
  logic [IW-1:0] mag;
  logic          rbit, sticky, inc;

  always_comb begin
    s      = f[31];
    e      = f[30:23];
    sig    = {|e, f[22:0]};
    lsh    = 6'(e - 8'd150);
    rsh    = 8'd150 - e;
    wide   = {sig, 26'b0} >> rsh;
    q      = '0;
    inv    = 1'b0;
    inx    = 1'b0;
    mag    = '0;
    rbit   = 1'b0;
    sticky = 1'b0;
    inc    = 1'b0;
    if (e == 8'hFF || e > 8'd190 || (e == 8'd190 && !(s && f[22:0] == 23'd0))) begin
      inv = 1'b1;
      q   = INT_INDEF;
    end else if (e == 8'd190) begin
      q = INT_INDEF;
    end else if (e >= 8'd150) begin
      mag = {40'b0, sig} << lsh;
      q   = s ? -mag : mag;
    end else begin
      if (rsh > 8'd25) begin
        sticky = |sig;
      end else begin
        mag    = {40'b0, wide[49:26]};
        rbit   = wide[25];
        sticky = |wide[24:0];
      end
      unique case (rm)
        RM_NEAR: inc = rbit & (sticky | mag[0]);
        RM_DOWN: inc = s & (rbit | sticky);
        RM_UP:   inc = !s & (rbit | sticky);
        default: inc = 1'b0;
      endcase
      mag = mag + {{(IW-1){1'b0}}, inc};
      q   = s ? -mag : mag;
      inx = rbit | sticky;
    end
  end

  always_comb begin
    p_inv_excl_inx_r10: assert (!(inv && inx));
    if (inv) p_inv_indef_r9: assert (q == INT_INDEF);
  end
endmodule

// File: rtl/cvt_lane.sv
module cvt_lane
  import cvt_pkg::*;
(
  input  logic [FW-1:0] elem,
  input  rmode_t        rm,
  input  logic          live,
  input  logic          take,
  input  logic          zero_mode,
  input  logic [IW-1:0] old,
  output logic [IW-1:0] res,
  output logic          inv_o,
  output logic          inx_o
);
  logic [IW-1:0] q;
  logic          inv, inx;

  cvt_f32_i64 u_cvt (
    .f   (elem),
    .rm  (rm),
    .q   (q),
    .inv (inv),
    .inx (inx)
  );

  always_comb begin
    if (!live)          res = '0;
    else if (take)      res = q;
    else if (zero_mode) res = '0;
    else                res = old;
    inv_o = live & take & inv;
    inx_o = live & take & inx;
  end

  always_comb begin
    if (!live) p_dead_lane_zero_r2: assert (res == '0 && !inv_o && !inx_o);
  end
endmodule

// File: rtl/pack_cvt_unit.sv
module pack_cvt_unit
  import cvt_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*FW-1:0] src,
  input  logic [LANES*IW-1:0] old_dst,
  input  logic [LANES-1:0]    wmask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic [1:0]          vlen,
  input  logic                bcast,
  input  logic                src_is_mem,
  input  logic                er_en,
  input  logic [1:0]          er_rc,
  input  logic [1:0]          glb_rc,
  input  logic [3:0]          rsvd,
  output logic                out_valid,
  output logic [LANES*IW-1:0] dst,
  output logic                flag_inv,
  output logic                flag_inx,
  output logic                ud_fault
);
  localparam int unsigned DW = LANES * IW;
  localparam int unsigned CW = $clog2(LANES + 1);

  rmode_t          rm;
  logic [CW-1:0]   n_live;
  logic            bc_eff;
  logic            fault_c;
  logic [LANES-1:0] lane_inv, lane_inx;
  logic [DW-1:0]   lanes_res;
  logic [DW-1:0]   dst_d;
  logic            inv_d, inx_d;

  cvt_rc_sel u_rc (
    .vlen       (vlen),
    .src_is_mem (src_is_mem),
    .er_en      (er_en),
    .er_rc      (er_rc),
    .glb_rc     (glb_rc),
    .rm         (rm)
  );

  always_comb begin
    unique case (vlen)
      2'b00:   n_live = CW'(2);
      2'b01:   n_live = CW'(4);
      default: n_live = CW'(8);
    endcase
    bc_eff  = src_is_mem & bcast;
    fault_c = (rsvd != 4'b1111);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FW-1:0] elem;
    assign elem = bc_eff ? src[FW-1:0] : src[FW*j +: FW];
    cvt_lane u_lane (
      .elem      (elem),
      .rm        (rm),
      .live      (CW'(j) < n_live),
      .take      (!mask_en || wmask[j]),
      .zero_mode (zero_mode),
      .old       (old_dst[IW*j +: IW]),
      .res       (lanes_res[IW*j +: IW]),
      .inv_o     (lane_inv[j]),
      .inx_o     (lane_inx[j])
    );
  end

  always_comb begin
    dst_d = fault_c ? old_dst : lanes_res;
    inv_d = !fault_c && (|lane_inv);
    inx_d = !fault_c && (|lane_inx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flag_inv  <= 1'b0;
      flag_inx  <= 1'b0;
      ud_fault  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst      <= dst_d;
        flag_inv <= inv_d;
        flag_inx <= inx_d;
        ud_fault <= fault_c;
      end
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst) && $stable(flag_inv) && $stable(ud_fault));
  p_fault_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ud_fault) |-> (dst == $past(old_dst)) && !flag_inv && !flag_inx);
  p_above_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ud_fault && $past(vlen) == 2'b00) |-> (dst[DW-1:2*IW] == '0));
  p_masked_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mask_en) && $past(wmask) == '0) |-> (!flag_inv && !flag_inx));
endmodule

// File: tb/pack_cvt_unit_test.sv
`timescale 1ns/1ps
module pack_cvt_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [255:0] src;
  logic [511:0] old_dst;
  logic [7:0]   wmask;
  logic         mask_en, zero_mode, bcast, src_is_mem, er_en;
  logic [1:0]   vlen, er_rc, glb_rc;
  logic [3:0]   rsvd;
  logic         out_valid, flag_inv, flag_inx, ud_fault;
  logic [511:0] dst;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;
  logic [31:0] fval [8] = '{32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000,
                            32'h40A00000, 32'h40C00000, 32'h40E00000, 32'h41000000};

  pack_cvt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode), .vlen(vlen),
    .bcast(bcast), .src_is_mem(src_is_mem), .er_en(er_en), .er_rc(er_rc),
    .glb_rc(glb_rc), .rsvd(rsvd), .out_valid(out_valid), .dst(dst),
    .flag_inv(flag_inv), .flag_inx(flag_inx), .ud_fault(ud_fault)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic defaults();
    in_valid = 0; vlen = 2'b10; mask_en = 0; wmask = 8'hFF; zero_mode = 0;
    bcast = 0; src_is_mem = 0; er_en = 0; er_rc = 2'b00; glb_rc = 2'b00;
    rsvd = 4'hF; old_dst = '0;
    for (int j = 0; j < 8; j++) src[32*j +: 32] = fval[j];
  endtask

  task automatic go();
    @(negedge clk); in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  function automatic logic [63:0] ln(int j);
    return dst[64*j +: 64];
  endfunction

  task automatic t_reset();
    chk("R1 reset valid", {63'b0, out_valid}, 64'd0);
    chk("R1 reset dst", {63'b0, |dst}, 64'd0);
    chk("R1 reset flags", {61'b0, flag_inv, flag_inx, ud_fault}, 64'd0);
  endtask

  task automatic t_basic();
    logic [511:0] snap;
    defaults(); go();
    chk("R1 valid pulse", {63'b0, out_valid}, 64'd1);
    for (int j = 0; j < 8; j++) chk($sformatf("R3 lane %0d", j), ln(j), 64'(j + 1));
    chk("R10 exact no inexact", {62'b0, flag_inv, flag_inx}, 64'd0);
    snap = dst;
    src = '1;
    @(negedge clk);
    chk("R1 valid drops", {63'b0, out_valid}, 64'd0);
    chk("R1 dst holds", {63'b0, dst == snap}, 64'd1);
  endtask

  task automatic t_vlen();
    defaults(); old_dst = '1; vlen = 2'b00; go();
    chk("R2 len2 lane1", ln(1), 64'd2);
    for (int j = 2; j < 8; j++) chk($sformatf("R2 len2 lane %0d zero", j), ln(j), 64'd0);
    defaults(); old_dst = '1; vlen = 2'b01; mask_en = 1; wmask = 8'h00; go();
    for (int j = 0; j < 4; j++) chk($sformatf("R2 len4 merged lane %0d", j), ln(j), '1);
    for (int j = 4; j < 8; j++) chk($sformatf("R2 len4 lane %0d zero", j), ln(j), 64'd0);
    defaults(); vlen = 2'b11; go();
    chk("R2 code11 lane7", ln(7), 64'd8);
  endtask

  task automatic t_round();
    logic [63:0] e25 [4] = '{64'd2, 64'd2, 64'd3, 64'd2};
    logic [63:0] em15 [4] = '{-64'sd2, -64'sd2, -64'sd1, -64'sd1};
    for (int m = 0; m < 4; m++) begin
      defaults(); src[31:0] = 32'h40200000; src[63:32] = 32'hBFC00000; glb_rc = 2'(m); go();
      chk($sformatf("R4 mode %0d 2.5", m), ln(0), e25[m]);
      chk($sformatf("R4 mode %0d -1.5", m), ln(1), em15[m]);
      chk($sformatf("R10 mode %0d inexact", m), {63'b0, flag_inx}, 64'd1);
    end
    defaults(); src[31:0] = 32'h40200000; src[63:32] = 32'hBFC00000;
    er_en = 1; er_rc = 2'b10; go();
    chk("R5 override reg full", ln(0), 64'd3);
    chk("R5 override reg full neg", ln(1), -64'sd1);
    src_is_mem = 1; go();
    chk("R5 no override mem", ln(0), 64'd2);
    src_is_mem = 0; vlen = 2'b01; go();
    chk("R5 no override len4", ln(1), -64'sd2);
    vlen = 2'b10; er_en = 0; go();
    chk("R5 override disabled", ln(0), 64'd2);
  endtask

  task automatic t_bcast();
    defaults(); src_is_mem = 1; bcast = 1; go();
    for (int j = 0; j < 8; j++) chk($sformatf("R6 bcast lane %0d", j), ln(j), 64'd1);
    defaults(); bcast = 1; go();
    chk("R6 reg ignores bcast lane5", ln(5), 64'd6);
    chk("R6 reg ignores bcast lane7", ln(7), 64'd8);
  endtask

  task automatic t_mask();
    defaults(); mask_en = 1; wmask = 8'h55;
    for (int j = 0; j < 8; j++) old_dst[64*j +: 64] = 64'hA0 + 64'(j);
    go();
    for (int j = 0; j < 8; j++)
      chk($sformatf("R8 merge lane %0d", j), ln(j), (j % 2 == 0) ? 64'(j + 1) : 64'hA0 + 64'(j));
    zero_mode = 1; go();
    chk("R8 zero lane1", ln(1), 64'd0);
    chk("R8 zero lane6", ln(6), 64'd7);
    mask_en = 0; wmask = 8'h00; go();
    chk("R7 mask off lane3", ln(3), 64'd4);
    chk("R7 mask off lane7", ln(7), 64'd8);
  endtask

  task automatic t_invalid();
    defaults(); src[31:0] = 32'h7FC00000; go();
    chk("R9 NaN value", ln(0), INDEF);
    chk("R9 NaN flags", {62'b0, flag_inv, flag_inx}, 64'd2);
    defaults(); src[31:0] = 32'hDF000000; src[63:32] = 32'h5E800000; go();
    chk("R9 min int", ln(0), INDEF);
    chk("R9 2^62", ln(1), 64'h4000_0000_0000_0000);
    chk("R9 min int no flag", {63'b0, flag_inv}, 64'd0);
    defaults(); src[31:0] = 32'h5F000000; src[63:32] = 32'hFF800000; go();
    chk("R9 2^63 value", ln(0), INDEF);
    chk("R9 -inf value", ln(1), INDEF);
    chk("R9 overflow flag", {63'b0, flag_inv}, 64'd1);
    defaults(); src[31:0] = 32'h3E800000; glb_rc = 2'b10; go();
    chk("R10 quarter up", ln(0), 64'd1);
    chk("R10 quarter flags", {62'b0, flag_inv, flag_inx}, 64'd1);
    defaults(); mask_en = 1; wmask = 8'hF7; src[127:96] = 32'h7FC00000;
    old_dst[255:192] = 64'h55; go();
    chk("R11 masked NaN keeps old", ln(3), 64'h55);
    chk("R11 masked NaN no flag", {63'b0, flag_inv}, 64'd0);
    defaults(); vlen = 2'b01; src[191:160] = 32'h7FC00000; src[223:192] = 32'h3E800000; go();
    chk("R11 dead lane NaN no flag", {62'b0, flag_inv, flag_inx}, 64'd0);
    chk("R11 dead lane zero", ln(5), 64'd0);
  endtask

  task automatic t_fault();
    defaults(); rsvd = 4'b0111; src = '1; old_dst = {8{64'h1234_5678_9ABC_DEF0}}; go();
    chk("R12 fault raised", {63'b0, ud_fault}, 64'd1);
    chk("R12 dst kept", {63'b0, dst == old_dst}, 64'd1);
    chk("R12 flags clear", {62'b0, flag_inv, flag_inx}, 64'd0);
    rsvd = 4'b1111; go();
    chk("R12 fault clear", {63'b0, ud_fault}, 64'd0);
    chk("R12 result NaN after clear", ln(0), INDEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_vlen();
    t_round();
    t_bcast();
    t_mask();
    t_invalid();
    t_fault();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule